// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives stereo audio from a host that drives a bit clock, a left/right frame clock and one serial data line. It runs only as a slave. Every register in it is clocked by the bit clock, and it samples data and frame clock on the rising edge. It turns each frame into a pair of parallel two's-complement samples and raises a valid strobe for them. The host picks one of three framings: standard I2S, data aligned to the start of the slot, or data aligned to the end of the slot. It also picks the word length, 16, 18 or 20 bits. The two choices are independent of each other. Shorter words are sign-extended to the 20-bit output.

The receiver counts the bit clocks in every frame. It stays muted until two complete frames in a row have the same length. While it is muted, both sample outputs read zero and no strobe is issued. When a frame of a different length arrives, the receiver drops back to the muted state and then locks again in the same way.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is active, and after it is released until lock, `locked_o` and `valid_o` are 0 and both sample outputs are zero.
- R2: Framing select 00 (I2S): a low frame clock marks the left slot. The word's MSB is the bit sampled one bit clock after the frame clock changes. Bits that follow the word within the slot are ignored.
- R3: Framing select 01 (start-aligned): a high frame clock marks the left slot. The MSB is the bit sampled in the first bit clock of the slot, data comes MSB first, and bits after the word are ignored.
- R4: Framing select 10 or 11 (end-aligned): a high frame clock marks the left slot. The LSB is the last bit before the frame clock changes, and earlier bits of the slot are ignored.
- R5: Length select 00 gives a 16-bit word, 01 gives 18 bits, and 10 or 11 gives 20 bits. A shorter word is sign-extended from its own MSB to 20 bits.
- R6: A frame runs from the start of a left slot to the start of the next left slot. Lock is declared at the start of a frame that follows two complete frames of equal bit-clock count. The first strobe carries the second of those two frames.
- R7: When a completed frame's bit-clock count differs from the previous frame's, `locked_o` falls, both outputs become zero and no strobe is issued. Lock returns under R6.
- R8: While locked, `valid_o` is high for exactly one cycle, one bit clock after the first rising edge of the following frame has been sampled. It carries the left and right samples of the frame just completed, and the outputs hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the host; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| lrck | input | 1 | Left/right frame clock from the host |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 2 | Framing select: 00 I2S, 01 start-aligned, 1x end-aligned |
| len_sel | input | 2 | Word length select: 00 16 bits, 01 18 bits, 1x 20 bits |
| left_o | output | 20 | Left sample, two's complement |
| right_o | output | 20 | Right sample, two's complement |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |
| locked_o | output | 1 | High while frame synchronisation holds |

## Verification
The assertions assume four things about the inputs. Frame clock and data change only away from the rising bit-clock edge. The framing and length selects change only while reset is active. Every slot is at least three bit clocks long. No slot is shorter than the selected word. The bench keeps to all four: it drives every input on the falling edge and applies reset before each new format. It sizes its slots at or above the word length. It also puts deliberate garbage in the padding bits, so that the ignored positions are exercised rather than left at zero.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S   = 2'b00,
      FMT_START = 2'b01,
      FMT_END   = 2'b10
   } aud_fmt_e;

   // End-aligned framing covers both 10 and 11
   function automatic logic fmt_is_end(input logic [1:0] sel);
      return sel[1];
   endfunction

   function automatic logic fmt_is_i2s(input logic [1:0] sel);
      return sel == FMT_I2S;
   endfunction

endpackage

// File: rtl/aud_rx_frame_align.sv
module aud_rx_frame_align
   import aud_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] fmt_sel,
   input  logic       lrck,
   output logic       slot_end_o,
   output logic       left_now_o
);

   logic lr_d1;
   logic fc_prev;
   logic fc;
   logic i2s;

   assign i2s = fmt_is_i2s(fmt_sel);

   // In I2S the word trails the frame clock by one bit, so a delayed copy
   // of the frame clock lines the slot up with its MSB.
   assign fc         = i2s ? lr_d1 : lrck;
   assign slot_end_o = fc != fc_prev;
   assign left_now_o = i2s ? ~fc : fc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lr_d1   <= 1'b0;
         fc_prev <= 1'b0;
      end else begin
         lr_d1   <= lrck;
         fc_prev <= fc;
      end
   end

endmodule

// File: rtl/aud_rx_slot_shift.sv
module aud_rx_slot_shift #(
   parameter int WMAX = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            slot_start,
   input  logic            sd,
   input  logic            end_aligned,
   input  logic [1:0]      len_sel,
   output logic [WMAX-1:0] word_o
);

   localparam int CW    = $clog2(WMAX + 1);
   localparam int NLEN  = 3;

   logic [WMAX-1:0] sh;
   logic [CW-1:0]   cnt;
   logic [CW-1:0]   wlen;
   logic [WMAX-1:0] ext [NLEN];
   logic [1:0]      lidx;

   assign lidx = (len_sel == 2'b00) ? 2'd0 : (len_sel == 2'b01) ? 2'd1 : 2'd2;
   assign wlen = (len_sel == 2'b00) ? CW'(16) : (len_sel == 2'b01) ? CW'(18) : CW'(20);

   // One sign-extended view per supported word length
   for (genvar k = 0; k < NLEN; k++) begin : g_len
      localparam int L  = 16 + 2 * k;
      localparam int SH = WMAX - L;
      logic signed [WMAX-1:0] up;
      assign up     = sh << SH;
      assign ext[k] = up >>> SH;
   end

   assign word_o = ext[lidx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else if (slot_start) begin
         sh  <= {{(WMAX-1){1'b0}}, sd};
         cnt <= CW'(1);
      end else if (end_aligned) begin
         sh  <= {sh[WMAX-2:0], sd};
      end else if (cnt < wlen) begin
         sh  <= {sh[WMAX-2:0], sd};
         cnt <= cnt + CW'(1);
      end
   end

   // R3: once a start-aligned word is complete, later bits leave it untouched
   assert_word_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!end_aligned && !slot_start && cnt >= wlen) |=> $stable(sh));

endmodule

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
   parameter int MAX_FRAME_BITS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_start,
   output logic lock_next_o,
   output logic locked_o
);

   localparam int          CNT_W = $clog2(MAX_FRAME_BITS + 1);
   localparam [CNT_W-1:0]  FMAX  = CNT_W'(MAX_FRAME_BITS);

   logic [CNT_W-1:0] fcnt;
   logic [CNT_W-1:0] prev_len;
   logic             seen;
   logic             have_prev;
   logic             locked;

   always_comb begin
      lock_next_o = locked;
      if (frame_start && seen) begin
         if (!have_prev) lock_next_o = 1'b0;
         else            lock_next_o = (fcnt == prev_len) && (fcnt != FMAX);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt      <= '0;
         prev_len  <= '0;
         seen      <= 1'b0;
         have_prev <= 1'b0;
         locked    <= 1'b0;
      end else begin
         locked <= lock_next_o;
         if (frame_start) begin
            fcnt <= CNT_W'(1);
            seen <= 1'b1;
            if (seen) begin
               prev_len  <= fcnt;
               have_prev <= 1'b1;
            end
         end else if (fcnt != FMAX) begin
            fcnt <= fcnt + CNT_W'(1);
         end
      end
   end

   assign locked_o = locked;

   // R6: lock is only ever gained on a frame boundary
   assert_lock_at_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(frame_start));

   // R7: a frame of a new length always removes lock
   assert_drop_on_mismatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && have_prev && fcnt != prev_len) |=> !locked);

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
   import aud_rx_pkg::*;
#(
   parameter int WMAX           = 20,
   parameter int MAX_FRAME_BITS = 128
) (
   input  logic            bclk,
   input  logic            rst_n,
   input  logic            lrck,
   input  logic            sdata,
   input  logic [1:0]      fmt_sel,
   input  logic [1:0]      len_sel,
   output logic [WMAX-1:0] left_o,
   output logic [WMAX-1:0] right_o,
   output logic            valid_o,
   output logic            locked_o
);

   if (WMAX < 20) begin : g_bad_width
      $error("WMAX must hold the longest 20-bit word");
   end
   if (MAX_FRAME_BITS < 2 * WMAX) begin : g_bad_frame
      $error("MAX_FRAME_BITS must cover two full-width slots");
   end

   logic            slot_end;
   logic            left_now;
   logic            frame_start;
   logic            right_start;
   logic            lock_next;
   logic [WMAX-1:0] word;
   logic [WMAX-1:0] left_hold;

   aud_rx_frame_align u_align (
      .clk        (bclk),
      .rst_n      (rst_n),
      .fmt_sel    (fmt_sel),
      .lrck       (lrck),
      .slot_end_o (slot_end),
      .left_now_o (left_now)
   );

   aud_rx_slot_shift #(.WMAX(WMAX)) u_shift (
      .clk         (bclk),
      .rst_n       (rst_n),
      .slot_start  (slot_end),
      .sd          (sdata),
      .end_aligned (fmt_is_end(fmt_sel)),
      .len_sel     (len_sel),
      .word_o      (word)
   );

   assign frame_start = slot_end && left_now;
   assign right_start = slot_end && !left_now;

   aud_rx_sync #(.MAX_FRAME_BITS(MAX_FRAME_BITS)) u_sync (
      .clk         (bclk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .lock_next_o (lock_next),
      .locked_o    (locked_o)
   );

   always_ff @(posedge bclk or negedge rst_n) begin
      if (!rst_n) begin
         left_hold <= '0;
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (right_start) left_hold <= word;
         if (frame_start) begin
            if (lock_next) begin
               left_o  <= left_hold;
               right_o <= word;
               valid_o <= 1'b1;
            end else begin
               left_o  <= '0;
               right_o <= '0;
            end
         end
      end
   end

   // R6: no strobe leaves the block unless synchronisation holds
   assert_valid_locked_R6: assert property (@(posedge bclk) disable iff (!rst_n)
      valid_o |-> locked_o);

   // R7: unlocked means silent outputs
   assert_mute_unlocked_R7: assert property (@(posedge bclk) disable iff (!rst_n)
      !locked_o |-> (left_o == '0 && right_o == '0));

   // R8: strobe is a single-cycle pulse
   assert_single_pulse_R8: assert property (@(posedge bclk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R8: outputs hold between strobes
   assert_hold_outputs_R8: assert property (@(posedge bclk) disable iff (!rst_n)
      (!frame_start && locked_o) |=> ($stable(left_o) && $stable(right_o)));

endmodule

// File: tb/aud_serial_rx_tb.sv
module aud_serial_rx_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lrck = 1'b0;
   logic        sdata = 1'b0;
   logic [1:0]  fmt_sel = 2'b01;
   logic [1:0]  len_sel = 2'b10;
   logic [19:0] left_o, right_o;
   logic        valid_o, locked_o;

   int    n_chk = 0;
   int    n_fail = 0;
   int    valid_cnt = 0;
   string cur_tag = "R3";
   logic [19:0] last_l = '0, last_r = '0;
   logic  carry = 1'b0;
   logic  prev_valid = 1'b0, prev_locked = 1'b0;
   logic  mute_seen = 1'b0, mute_ok = 1'b0;

   always #10 clk = ~clk;

   aud_serial_rx u_dut (
      .bclk     (clk),
      .rst_n    (rst_n),
      .lrck     (lrck),
      .sdata    (sdata),
      .fmt_sel  (fmt_sel),
      .len_sel  (len_sel),
      .left_o   (left_o),
      .right_o  (right_o),
      .valid_o  (valid_o),
      .locked_o (locked_o)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [19:0] sext(input logic [19:0] w, input int n);
      logic [19:0] r = w;
      for (int b = n; b < 20; b++) r[b] = w[n-1];
      return r;
   endfunction

   // monitor: data on every strobe, pulse width, mute at loss of lock
   always @(negedge clk) begin
      if (rst_n) begin
         if (valid_o) begin
            valid_cnt++;
            chk(left_o == last_l, cur_tag, "left sample", left_o, last_l);
            chk(right_o == last_r, cur_tag, "right sample", right_o, last_r);
            chk(!prev_valid, "R8", "strobe width", 32'(prev_valid), 0);
         end
         if (prev_locked && !locked_o) begin
            mute_seen = 1'b1;
            mute_ok   = (left_o == '0) && (right_o == '0) && !valid_o;
         end
      end
      prev_valid  = valid_o;
      prev_locked = locked_o;
   end

   task automatic drive_bit(input logic lr, input logic d);
      @(negedge clk);
      lrck = lr;
      if (fmt_sel == 2'b00) begin
         sdata = carry;
         carry = d;
      end else begin
         sdata = d;
      end
   endtask

   task automatic do_reset(input logic [1:0] f, input logic [1:0] l);
      @(negedge clk);
      rst_n   = 1'b0;
      fmt_sel = f;
      len_sel = l;
      lrck    = (f == 2'b00) ? 1'b1 : 1'b0;   // idle in the right slot
      sdata   = 1'b0;
      carry   = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      valid_cnt = 0;
      mute_seen = 1'b0;
      mute_ok   = 1'b0;
   endtask

   task automatic send_slot(input logic lr, input logic [19:0] w, input int n, input int slot);
      for (int i = 0; i < slot; i++) begin
         logic b;
         if (fmt_sel[1]) begin
            int idx = i - (slot - n);
            b = (idx >= 0) ? w[n-1-idx] : ~i[0];
         end else begin
            b = (i < n) ? w[n-1-i] : i[0];
         end
         drive_bit(lr, b);
      end
   endtask

   task automatic send_frame(input logic [19:0] l, input logic [19:0] r, input int n, input int slot);
      logic left_lv = (fmt_sel == 2'b00) ? 1'b0 : 1'b1;
      send_slot(left_lv, l, n, slot);
      send_slot(~left_lv, r, n, slot);
      last_l = sext(l, n);
      last_r = sext(r, n);
   endtask

   task automatic test_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(locked_o == 1'b0, "R1", "locked in reset", 32'(locked_o), 0);
      chk(valid_o == 1'b0, "R1", "valid in reset", 32'(valid_o), 0);
      chk(left_o == '0 && right_o == '0, "R1", "samples in reset", {12'h0, left_o}, 0);
   endtask

   task automatic test_start_aligned_20();
      do_reset(2'b01, 2'b10);
      cur_tag = "R3";
      send_frame(20'h12345, 20'h8ABCD, 20, 20);
      send_frame(20'h7FFFF, 20'h80000, 20, 20);
      chk(locked_o == 1'b0, "R6", "not locked after two frames", 32'(locked_o), 0);
      chk(left_o == '0, "R1", "silent before lock", {12'h0, left_o}, 0);
      send_frame(20'h00001, 20'hFFFFF, 20, 20);
      send_frame(20'h55555, 20'hAAAAA, 20, 20);
      send_frame(20'h0, 20'h0, 20, 20);
      chk(valid_cnt == 3, "R6", "strobes, start-aligned", 32'(valid_cnt), 3);
      chk(locked_o == 1'b1, "R6", "locked", 32'(locked_o), 1);
   endtask

   task automatic test_i2s_16();
      do_reset(2'b00, 2'b00);
      cur_tag = "R2";
      send_frame(20'h08000, 20'h07FFF, 16, 32);
      send_frame(20'h0ABCD, 20'h01234, 16, 32);
      send_frame(20'h0FFFF, 20'h00001, 16, 32);
      send_frame(20'h0, 20'h0, 16, 32);
      chk(valid_cnt == 2, "R2", "strobes, I2S", 32'(valid_cnt), 2);
      chk(left_o == 20'hFFFFF && right_o == 20'h00001, "R5", "16-bit sign extension",
          {12'h0, left_o}, 32'hFFFFF);
   endtask

   task automatic test_end_aligned_18();
      do_reset(2'b10, 2'b01);
      cur_tag = "R4";
      send_frame(20'h20001, 20'h1FFFF, 18, 24);
      send_frame(20'h3C3C3, 20'h00F0F, 18, 24);
      send_frame(20'h2AAAA, 20'h15555, 18, 24);
      send_frame(20'h0, 20'h0, 18, 24);
      chk(valid_cnt == 2, "R4", "strobes, end-aligned", 32'(valid_cnt), 2);
      chk(left_o == 20'hEAAAA, "R5", "18-bit sign extension", {12'h0, left_o}, 32'hEAAAA);
   endtask

   task automatic test_start_aligned_16_pad();
      do_reset(2'b01, 2'b00);
      cur_tag = "R3";
      send_frame(20'h0F00F, 20'h08001, 16, 20);
      send_frame(20'h01234, 20'h0FEDC, 16, 20);
      send_frame(20'h0, 20'h0, 16, 20);
      chk(valid_cnt == 1, "R3", "strobes, padded slots", 32'(valid_cnt), 1);
      chk(right_o == 20'hFFEDC, "R3", "trailing padding ignored", {12'h0, right_o}, 32'hFFEDC);
   endtask

   task automatic test_mismatch();
      do_reset(2'b11, 2'b10);
      cur_tag = "R4";
      send_frame(20'h11111, 20'h22222, 20, 20);
      send_frame(20'h33333, 20'h44444, 20, 20);
      send_frame(20'h55555, 20'h66666, 20, 20);
      cur_tag = "R7";
      send_frame(20'h77777, 20'h88888, 20, 24);
      send_frame(20'h99999, 20'hAAAAA, 20, 24);
      chk(mute_seen == 1'b1, "R7", "lock lost on length change", 32'(mute_seen), 1);
      chk(mute_ok == 1'b1, "R7", "outputs silent at loss", 32'(mute_ok), 1);
      send_frame(20'hBBBBB, 20'hCCCCC, 20, 24);
      send_frame(20'h0, 20'h0, 20, 24);
      chk(valid_cnt == 4, "R7", "strobes around relock", 32'(valid_cnt), 4);
      chk(locked_o == 1'b1, "R7", "relocked", 32'(locked_o), 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      test_reset();
      test_start_aligned_20();
      test_i2s_16();
      test_end_aligned_18();
      test_start_aligned_16_pad();
      test_mismatch();
      repeat (4) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule